// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps three tables of single-bit entries, each with 16384 entries. The per-branch table is indexed by the branch address and remembers that branch's most recent direction. The correlating table is indexed by the branch address XORed with an 11-bit register of recent resolved outcomes. A chooser table, indexed by the branch address like the per-branch table, records for each branch which of the two tables to trust. The final guess is taken from the table that the chooser names.

The fetch side presents a branch address on the lookup port. One clock later it receives the guess, the chooser decision and the history value used to form the index. When the branch resolves, the back end returns the same address, that history snapshot and the real direction on the update port. The update trains all three tables and shifts the outcome into the history register. Redirection and recovery of the pipeline are handled outside this block.

Top module: `bp_tournament`

## Requirements
- R1: After reset, every lookup returns not-taken with `lk_use_global_o`=0, the history register is zero and `lk_valid_o` is low until a lookup is made.
- R2: `lk_valid_o` is high in exactly the cycles that follow a cycle with `lk_valid_i` high. `lk_taken_o`, `lk_use_global_o` and `lk_hist_o` are registered together with it.
- R3: The per-branch entry is selected by address bits [15:2]. When the chooser selects this table, the guess equals the outcome of the last update to that entry.
- R4: The correlating entry is selected by address bits [15:2] XOR the 11-bit history, with the history zero-extended to 14 bits at the least significant end.
- R5: The chooser entry shares the per-branch index. A value of 0 selects the per-branch table and 1 selects the correlating table. This value appears on `lk_use_global_o`, and `lk_taken_o` equals the selected entry (1 = taken).
- R6: A valid update overwrites the per-branch entry at its address index, and the correlating entry at its address-XOR-snapshot index, with `up_taken_i`.
- R7: A valid update changes the chooser entry only when the two entries it reads disagree. The chooser is then set to 1 if the correlating entry matched the outcome and to 0 otherwise.
- R8: Each valid update shifts `up_taken_i` into history bit 0 and discards bit 10. The history does not change in any other cycle.
- R9: When a lookup and an update reach the same entry in one cycle, the lookup reports the value from before that update.
- R10: While `up_valid_i` is low, the update fields have no effect on any table or on the history.
- R11: `lk_hist_o` is the history value that was current in the cycle the lookup was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_pc_i | input | 32 | Branch address to look up |
| lk_valid_o | output | 1 | Lookup result valid |
| lk_taken_o | output | 1 | Predicted direction, 1 = taken |
| lk_use_global_o | output | 1 | Chooser decision, 1 = correlating table |
| lk_hist_o | output | 11 | History snapshot used by the lookup |
| up_valid_i | input | 1 | Update strobe |
| up_pc_i | input | 32 | Branch address of the resolved branch |
| up_hist_i | input | 11 | Snapshot returned by the lookup of that branch |
| up_taken_i | input | 1 | Resolved direction, 1 = taken |

## Verification
The hardest case to reach is a chooser flip. A flip needs the per-branch entry and the correlating entry of the same branch to hold opposite values. That can only happen after the history has moved, so the same address maps to a different correlating entry. The stimulus first trains a branch under one history value and shifts the history with an unrelated branch. It then resolves the first branch the other way. After that, a long random run over a few addresses forces frequent aliasing and same-cycle lookup and update collisions. A bench model predicts every registered result.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic {
    SEL_LOCAL  = 1'b0,
    SEL_GLOBAL = 1'b1
  } sel_e;
endpackage

// File: rtl/bp_bit_table.sv
// Single-bit table, two combinational read ports, one write port.
module bp_bit_table #(
  parameter int IDX_W = 14,
  localparam int N    = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_a_idx_i,
  output logic             rd_a_o,
  input  logic [IDX_W-1:0] rd_b_idx_i,
  output logic             rd_b_o,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_bit_i
);
  logic [N-1:0] bits_q;

  assign rd_a_o = bits_q[rd_a_idx_i];
  assign rd_b_o = bits_q[rd_b_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   bits_q <= '0;
    else if (we_i) bits_q[wr_idx_i] <= wr_bit_i;
  end
endmodule

// File: rtl/bp_ghist.sv
// Outcome history, newest outcome at bit 0.
module bp_ghist #(
  parameter int HIST_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [HIST_W-1:0] hist_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_o <= '0;
    else if (shift_i) hist_o <= {hist_o[HIST_W-2:0], bit_i};
  end
endmodule

// File: rtl/bp_tournament.sv
module bp_tournament
  import bp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 14,
  parameter int HIST_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [ADDR_W-1:0] lk_pc_i,
  output logic              lk_valid_o,
  output logic              lk_taken_o,
  output logic              lk_use_global_o,
  output logic [HIST_W-1:0] lk_hist_o,
  input  logic              up_valid_i,
  input  logic [ADDR_W-1:0] up_pc_i,
  input  logic [HIST_W-1:0] up_hist_i,
  input  logic              up_taken_i
);
  localparam int PAD_W = IDX_W - HIST_W;

  logic [HIST_W-1:0] ghist;
  logic [IDX_W-1:0]  lk_lidx, lk_gidx, up_lidx, up_gidx;
  logic              lk_loc, lk_glb, lk_cho;
  logic              up_loc, up_glb, up_cho_unused;
  logic              cho_we, cho_bit;
  sel_e              lk_sel;

  logic unused_pc;
  assign unused_pc = ^{lk_pc_i[ADDR_W-1:IDX_W+2], lk_pc_i[1:0],
                       up_pc_i[ADDR_W-1:IDX_W+2], up_pc_i[1:0]};

  assign lk_lidx = lk_pc_i[IDX_W+1:2];
  assign up_lidx = up_pc_i[IDX_W+1:2];
  assign lk_gidx = lk_lidx ^ {{PAD_W{1'b0}}, ghist};
  assign up_gidx = up_lidx ^ {{PAD_W{1'b0}}, up_hist_i};

  bp_bit_table #(.IDX_W(IDX_W)) u_local (
    .clk_i, .rst_ni,
    .rd_a_idx_i(lk_lidx), .rd_a_o(lk_loc),
    .rd_b_idx_i(up_lidx), .rd_b_o(up_loc),
    .we_i(up_valid_i), .wr_idx_i(up_lidx), .wr_bit_i(up_taken_i)
  );

  bp_bit_table #(.IDX_W(IDX_W)) u_global (
    .clk_i, .rst_ni,
    .rd_a_idx_i(lk_gidx), .rd_a_o(lk_glb),
    .rd_b_idx_i(up_gidx), .rd_b_o(up_glb),
    .we_i(up_valid_i), .wr_idx_i(up_gidx), .wr_bit_i(up_taken_i)
  );

  // Chooser trains only when the components disagree.
  assign cho_we  = up_valid_i && (up_loc != up_glb);
  assign cho_bit = (up_glb == up_taken_i);

  bp_bit_table #(.IDX_W(IDX_W)) u_chooser (
    .clk_i, .rst_ni,
    .rd_a_idx_i(lk_lidx), .rd_a_o(lk_cho),
    .rd_b_idx_i(up_lidx), .rd_b_o(up_cho_unused),
    .we_i(cho_we), .wr_idx_i(up_lidx), .wr_bit_i(cho_bit)
  );

  bp_ghist #(.HIST_W(HIST_W)) u_hist (
    .clk_i, .rst_ni,
    .shift_i(up_valid_i), .bit_i(up_taken_i), .hist_o(ghist)
  );

  assign lk_sel = sel_e'(lk_cho);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_valid_o      <= 1'b0;
      lk_taken_o      <= 1'b0;
      lk_use_global_o <= 1'b0;
      lk_hist_o       <= '0;
    end else begin
      lk_valid_o <= lk_valid_i;
      if (lk_valid_i) begin
        lk_taken_o      <= (lk_sel == SEL_GLOBAL) ? lk_glb : lk_loc;
        lk_use_global_o <= lk_cho;
        lk_hist_o       <= ghist;
      end
    end
  end
endmodule

// File: rtl/bp_tournament_chk.sv
module bp_tournament_chk #(
  parameter int HIST_W = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lk_valid_i,
  input logic              lk_valid_o,
  input logic [HIST_W-1:0] lk_hist_o,
  input logic              up_valid_i,
  input logic              up_taken_i,
  input logic [HIST_W-1:0] ghist,
  input logic              up_loc,
  input logic              up_glb,
  input logic              cho_we
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> lk_valid_o); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |=> !lk_valid_o); // R2
  AST_HIST_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_valid_i |=> ghist == {$past(ghist[HIST_W-2:0]), $past(up_taken_i)}); // R8
  AST_HIST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !up_valid_i |=> $stable(ghist)); // R10
  AST_HIST_SNAPSHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> lk_hist_o == $past(ghist)); // R11
  AST_CHOOSER_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_loc == up_glb) |-> !cho_we); // R7
endmodule

bind bp_tournament bp_tournament_chk #(.HIST_W(HIST_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .lk_valid_i(lk_valid_i),
  .lk_valid_o(lk_valid_o), .lk_hist_o(lk_hist_o), .up_valid_i(up_valid_i),
  .up_taken_i(up_taken_i), .ghist(ghist), .up_loc(up_loc), .up_glb(up_glb),
  .cho_we(cho_we)
);

// File: tb/sim_bp_tournament.sv
module sim_bp_tournament;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        lk_valid_o, lk_taken_o, lk_use_global_o;
  logic [10:0] lk_hist_o;
  logic        up_valid = 1'b0;
  logic [31:0] up_pc = '0;
  logic [10:0] up_hist = '0;
  logic        up_taken = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct packed { logic taken; logic glob; logic [10:0] hist; } exp_t;
  exp_t exp_q[$];

  bit m_loc[int];
  bit m_glb[int];
  bit m_cho[int];
  logic [10:0] m_hist = '0;

  always #2.5 clk = ~clk;

  bp_tournament u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_valid_i(lk_valid), .lk_pc_i(lk_pc),
    .lk_valid_o(lk_valid_o), .lk_taken_o(lk_taken_o),
    .lk_use_global_o(lk_use_global_o), .lk_hist_o(lk_hist_o),
    .up_valid_i(up_valid), .up_pc_i(up_pc), .up_hist_i(up_hist),
    .up_taken_i(up_taken)
  );

  function automatic bit rd(ref bit t[int], input int i);
    return t.exists(i) ? t[i] : 1'b0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus, expected lookup result uses pre-update model (R9).
  task automatic step(input bit lv, input logic [31:0] lpc,
                      input bit uv, input logic [31:0] upc,
                      input logic [10:0] uh, input bit ut);
    int li, gi, ui, ug;
    bit lp, gp, cp;
    @(negedge clk);
    lk_valid = lv; lk_pc = lpc;
    up_valid = uv; up_pc = upc; up_hist = uh; up_taken = ut;
    if (lv) begin
      li = int'(lpc[15:2]);
      gi = li ^ int'(m_hist);            // R4
      lp = rd(m_loc, li); gp = rd(m_glb, gi); cp = rd(m_cho, li);
      exp_q.push_back('{taken: (cp ? gp : lp), glob: cp, hist: m_hist}); // R5 R11
    end
    if (uv) begin
      ui = int'(upc[15:2]);
      ug = ui ^ int'(uh);
      if (rd(m_loc, ui) != rd(m_glb, ug)) m_cho[ui] = (rd(m_glb, ug) == ut); // R7
      m_loc[ui] = ut;                    // R3 R6
      m_glb[ug] = ut;
      m_hist = {m_hist[9:0], ut};        // R8
    end
  endtask

  // Monitor / scoreboard
  initial begin
    exp_t e;
    forever begin
      @(posedge clk); #1;
      if (rst_n && lk_valid_o) begin
        if (exp_q.size() == 0) chk("R2 unexpected valid", 1, 0);
        else begin
          e = exp_q.pop_front();
          chk("R5 taken", lk_taken_o, e.taken);
          chk("R5 chooser", lk_use_global_o, e.glob);
          chk("R11 hist", lk_hist_o, e.hist);
        end
      end
    end
  end

  initial begin
    #(5 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b;
    repeat (3) @(negedge clk);
    chk("R1 valid low in reset", lk_valid_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid low after reset", lk_valid_o, 0);
    // R1: fresh lookups predict not-taken via per-branch table
    step(1, 32'h0000_1000, 0, 0, 0, 0);
    step(1, 32'hFFFF_FFFC, 0, 0, 0, 0);
    // R10: update fields with strobe low change nothing
    step(0, 0, 0, 32'h0000_1000, 11'h5A5, 1);
    step(1, 32'h0000_1000, 0, 0, 0, 0);
    // R3 R6: train branch a taken under history 0
    a = 32'h0000_2040; b = 32'h0000_3008;
    step(0, 0, 1, a, 11'h000, 1);
    step(1, a, 1, b, 11'h001, 0);        // lookup sees hist=1
    // R7: resolve a not-taken under hist 2: per-branch says taken, correlating says not
    step(1, a, 1, a, 11'h002, 0);        // R9 same-cycle collision
    step(1, a, 0, 0, 0, 0);
    step(1, a + 32'h0001_0000, 0, 0, 0, 0); // aliasing on upper bits, R3
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    chk("R2 valid drops", lk_valid_o, 0);
    // Random run: few addresses, frequent collisions and history wrap (R8)
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] lp, upc;
      bit lv, uv, ut;
      lv = $urandom_range(0, 3) != 0;
      uv = $urandom_range(0, 2) != 0;
      ut = $urandom_range(0, 1);
      lp = {16'($urandom_range(0, 3)), 11'h0, 3'($urandom_range(0, 7)), 2'b00};
      upc = ($urandom_range(0, 1) == 1) ? lp :
            {16'h0, 11'h0, 3'($urandom_range(0, 7)), 2'b00};
      step(lv, lp, uv, upc, m_hist, ut);
    end
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    chk("R2 queue drained", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule